// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with APB Access

This peripheral guards a system against software that has stopped responding. A 32-bit down-counter steps once on every clock cycle in which a counting-enable input is high. When the counter first runs out, it raises a raw interrupt flag. If software does not acknowledge that flag before the counter runs out a second time, the block sets a reset flag and freezes the counter. Software services the timer by acknowledging the interrupt, which also reloads the counter, or by writing a new reload value.

The registers sit behind a zero-wait-state APB slave. A guard register protects every other register against stray writes, and only one fixed key value opens it. A test mode lets software drive the interrupt and reset outputs directly. A build-time parameter selects a restricted variant. In that variant the test registers are absent, and the control register cannot be changed once its interrupt-enable bit has been set.

Top module: `wdg_apb`

## Requirements
- R1: After reset, RELOAD (0x000) and COUNT (0x004) read 0xFFFFFFFF, while CTRL (0x008), RAWSTAT (0x010), MSKSTAT (0x014), GUARD (0xC00) and TSTEN (0xF00) read 0. Both outputs are low.
- R2: COUNT decrements by one on each cycle with tickEn high. A write to RELOAD sets the reload value, loads it into COUNT immediately and restarts a halted counter.
- R3: The step from 1 to 0 is an expiry. With no interrupt pending, it sets RAWSTAT bit 0. On the next tick the counter reloads from RELOAD.
- R4: An expiry while RAWSTAT bit 0 is still set sets the reset flag and halts COUNT. The halt lasts until the next RELOAD write, and acknowledging does not end it.
- R5: Any write to ACK (0x00C) clears RAWSTAT bit 0 and copies RELOAD into COUNT.
- R6: CTRL bit 0 enables the interrupt and bit 1 enables the reset. Its other bits read 0. irqOut equals raw flag AND bit 0, rstOut equals reset flag AND bit 1, and MSKSTAT bit 0 reads raw flag AND bit 0.
- R7: Writing 0x1ACCE551 to GUARD unlocks the block and any other value locks it. GUARD reads 1 when locked and 0 when unlocked. While locked, writes to every offset except GUARD are ignored.
- R8: While TSTEN bit 0 is 1, irqOut follows TSTDRV (0xF04) bit 1 and rstOut follows TSTDRV bit 0.
- R9: With ALT_MODE=1, CTRL writes are ignored once CTRL bit 0 is set. TSTEN and TSTDRV then read 0, and writes to them have no effect.
- R10: Reads of ACK, TSTDRV and unmapped offsets return 0, and writes to COUNT, RAWSTAT and MSKSTAT have no effect. ID word k at 0xFD0+4k (k = 0..11) reads byte k of ID_TABLE.
- R11: pready is always 1 and pslverr is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Counting enable, one decrement per high cycle |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irqOut | output | 1 | Watchdog interrupt |
| rstOut | output | 1 | Watchdog reset request |

## Verification
A register write takes effect at the clock edge that ends the APB access phase, and the interrupt and reset outputs are decoded from registers without further delay, so both are valid half a cycle later. Read data is combinational and is sampled at the falling edge inside the access phase. An expiry updates the flags at the edge on which tickEn is sampled high with COUNT at 1. The bench therefore holds tickEn for an exact number of edges, lowers it before any bus access, and samples pins and read data only at falling edges after the relevant edge. A monitor compares each sampled result against a queue of expected values in issue order.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DW = 32;
  localparam int AW = 12;

  localparam logic [AW-1:0] OFF_RELOAD = 12'h000;
  localparam logic [AW-1:0] OFF_COUNT  = 12'h004;
  localparam logic [AW-1:0] OFF_CTRL   = 12'h008;
  localparam logic [AW-1:0] OFF_ACK    = 12'h00C;
  localparam logic [AW-1:0] OFF_RAW    = 12'h010;
  localparam logic [AW-1:0] OFF_MSK    = 12'h014;
  localparam logic [AW-1:0] OFF_GUARD  = 12'hC00;
  localparam logic [AW-1:0] OFF_TSTEN  = 12'hF00;
  localparam logic [AW-1:0] OFF_TSTDRV = 12'hF04;
  localparam logic [AW-1:0] OFF_ID_LO  = 12'hFD0;
  localparam logic [AW-1:0] OFF_ID_HI  = 12'hFFC;

  localparam logic [DW-1:0] GUARD_KEY  = 32'h1ACCE551;

  // strobes from control to counter datapath
  typedef struct packed {
    logic          reloadWr;
    logic          ackWr;
    logic [DW-1:0] wdata;
  } cnt_cmd_t;
endpackage

// File: rtl/wdg_cnt.sv
module wdg_cnt
  import wdg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  cnt_cmd_t      cmd,
  output logic [DW-1:0] count,
  output logic [DW-1:0] reloadVal,
  output logic          rawIrq,
  output logic          rstStat
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic halted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= '1;
      count     <= '1;
      rawIrq    <= 1'b0;
      rstStat   <= 1'b0;
      halted    <= 1'b0;
    end else if (cmd.reloadWr) begin
      reloadVal <= cmd.wdata;
      count     <= cmd.wdata;
      halted    <= 1'b0;
    end else if (cmd.ackWr) begin
      rawIrq <= 1'b0;
      count  <= reloadVal;
    end else if (tickEn && !halted) begin
      if (count == ONE) begin
        count <= '0;
        if (rawIrq) begin
          rstStat <= 1'b1;
          halted  <= 1'b1;
        end else begin
          rawIrq <= 1'b1;
        end
      end else if (count == '0) begin
        count <= reloadVal;
      end else begin
        count <= count - ONE;
      end
    end
  end
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter bit          ALT_MODE = 1'b0,
  parameter logic [95:0] ID_TABLE = 96'h0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output cnt_cmd_t      cmd,
  input  logic [DW-1:0] count,
  input  logic [DW-1:0] reloadVal,
  input  logic          rawIrq,
  output logic [1:0]    ctrlBits,
  output logic          testEn,
  output logic [1:0]    testDrv,
  output logic          locked
);
  logic          wrAcc;
  logic          wrOk;
  logic [AW-1:0] idOff;
  logic [3:0]    idIdx;
  logic          ctrlFrozen;

  assign wrAcc      = psel && penable && pwrite;
  assign wrOk       = wrAcc && (!locked || paddr == OFF_GUARD);
  assign ctrlFrozen = ALT_MODE && ctrlBits[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlBits <= '0;
      locked   <= 1'b0;
      testEn   <= 1'b0;
      testDrv  <= '0;
    end else if (wrOk) begin
      case (paddr)
        OFF_CTRL:   if (!ctrlFrozen) ctrlBits <= pwdata[1:0];
        OFF_GUARD:  locked <= (pwdata != GUARD_KEY);
        OFF_TSTEN:  if (!ALT_MODE) testEn <= pwdata[0];
        OFF_TSTDRV: if (!ALT_MODE) testDrv <= pwdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd.reloadWr = wrOk && (paddr == OFF_RELOAD);
    cmd.ackWr    = wrOk && (paddr == OFF_ACK);
    cmd.wdata    = pwdata;
  end

  assign idOff = paddr - OFF_ID_LO;
  assign idIdx = idOff[5:2];

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (paddr)
        OFF_RELOAD: prdata = reloadVal;
        OFF_COUNT:  prdata = count;
        OFF_CTRL:   prdata = {{(DW-2){1'b0}}, ctrlBits};
        OFF_RAW:    prdata = {{(DW-1){1'b0}}, rawIrq};
        OFF_MSK:    prdata = {{(DW-1){1'b0}}, rawIrq && ctrlBits[0]};
        OFF_GUARD:  prdata = {{(DW-1){1'b0}}, locked};
        OFF_TSTEN:  prdata = {{(DW-1){1'b0}}, testEn && !ALT_MODE};
        default: begin
          if (paddr >= OFF_ID_LO && paddr <= OFF_ID_HI && paddr[1:0] == 2'b00)
            prdata = {{(DW-8){1'b0}}, ID_TABLE[{idIdx, 3'b000} +: 8]};
        end
      endcase
    end
  end
endmodule

// File: rtl/wdg_apb.sv
module wdg_apb
  import wdg_pkg::*;
#(
  parameter bit          ALT_MODE = 1'b0,
  parameter logic [95:0] ID_TABLE = 96'h3CE1079D0000065200000011
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [11:0]   paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  output logic          irqOut,
  output logic          rstOut
);
  cnt_cmd_t      cmd;
  logic [DW-1:0] count;
  logic [DW-1:0] reloadVal;
  logic          rawIrq;
  logic          rstStat;
  logic [1:0]    ctrlBits;
  logic          testEn;
  logic [1:0]    testDrv;
  logic          locked;

  wdg_ctrl #(.ALT_MODE(ALT_MODE), .ID_TABLE(ID_TABLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cmd(cmd),
    .count(count), .reloadVal(reloadVal), .rawIrq(rawIrq),
    .ctrlBits(ctrlBits), .testEn(testEn), .testDrv(testDrv), .locked(locked)
  );

  wdg_cnt u_cnt (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmd(cmd),
    .count(count), .reloadVal(reloadVal), .rawIrq(rawIrq), .rstStat(rstStat)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign irqOut  = testEn ? testDrv[1] : (rawIrq && ctrlBits[0]);
  assign rstOut  = testEn ? testDrv[0] : (rstStat && ctrlBits[1]);
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
  parameter bit ALT_MODE = 1'b0
) (
  input logic        clk,
  input logic        rstN,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic        pready,
  input logic        pslverr,
  input logic        irqOut,
  input logic        rstOut,
  input logic [1:0]  ctrlBits,
  input logic        testEn,
  input logic [1:0]  testDrv,
  input logic        rawIrq,
  input logic        rstStat,
  input logic        locked,
  input logic [31:0] count,
  input logic        reloadWr,
  input logic        ackWr
);
  logic wrAcc;
  assign wrAcc = psel && penable && pwrite;

  // R11
  apb_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    pready && !pslverr);

  // R8
  test_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    testEn |-> (irqOut == testDrv[1]) && (rstOut == testDrv[0]));

  // R6
  mask_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |-> (irqOut == (rawIrq && ctrlBits[0])) && (rstOut == (rstStat && ctrlBits[1])));

  // R7
  lock_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && wrAcc && paddr != 12'hC00) |=> $stable(ctrlBits) && $stable(testEn) && $stable(testDrv));

  // R4
  halt_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstStat) |-> count == 32'h0);

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rstStat) && !reloadWr && !ackWr) |=> count == 32'h0);

  // R9
  sticky_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ALT_MODE && ctrlBits[0]) |=> ctrlBits[0]);

  // R9
  alt_no_test_chk: assert property (@(posedge clk) disable iff (!rstN)
    ALT_MODE |-> !testEn);
endmodule

bind wdg_apb wdg_chk #(.ALT_MODE(ALT_MODE)) u_chk (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pready(pready), .pslverr(pslverr), .irqOut(irqOut),
  .rstOut(rstOut), .ctrlBits(ctrlBits), .testEn(testEn), .testDrv(testDrv),
  .rawIrq(rawIrq), .rstStat(rstStat), .locked(locked), .count(count),
  .reloadWr(cmd.reloadWr), .ackWr(cmd.ackWr)
);

// File: tb/test_wdg_apb.sv
module test_wdg_apb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic        useAlt = 1'b0;
  logic        pinReq = 1'b0;

  logic [31:0] prdA, prdB;
  logic        prdyA, prdyB, perrA, perrB;
  logic        irqA, irqB, rstA, rstB;

  int compared = 0;
  int mismatched = 0;

  localparam logic [11:0] A_RELOAD = 12'h000, A_COUNT = 12'h004, A_CTRL = 12'h008,
                          A_ACK = 12'h00C, A_RAW = 12'h010, A_MSK = 12'h014,
                          A_GUARD = 12'hC00, A_TSTEN = 12'hF00, A_TSTDRV = 12'hF04;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  always #5 clk = ~clk;

  wdg_apb i_wdg_apb (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .psel(psel && !useAlt), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdA), .pready(prdyA),
    .pslverr(perrA), .irqOut(irqA), .rstOut(rstA)
  );

  wdg_apb #(.ALT_MODE(1'b1)) i_wdg_apb_alt (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .psel(psel && useAlt), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdB), .pready(prdyB),
    .pslverr(perrB), .irqOut(irqB), .rstOut(rstB)
  );

  typedef struct {
    string       tag;
    bit          isPin;
    logic [31:0] exp;
  } item_t;
  item_t sbq[$];

  function automatic void compare(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endfunction

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    item_t it;
    if (psel && penable && !pwrite) begin
      compare("R11 response", {30'h0, useAlt ? prdyB : prdyA, useAlt ? perrB : perrA}, 32'h2);
      if (sbq.size() == 0) compare("scoreboard underflow", 32'h1, 32'h0);
      else begin
        it = sbq.pop_front();
        compare(it.tag, useAlt ? prdB : prdA, it.exp);
      end
    end else if (pinReq) begin
      if (sbq.size() == 0) compare("scoreboard underflow", 32'h1, 32'h0);
      else begin
        it = sbq.pop_front();
        compare(it.tag, {30'h0, useAlt ? irqB : irqA, useAlt ? rstB : rstA}, it.exp);
      end
    end
  end

  task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = wr; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    apb(1'b1, a, d);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.tag = tag; it.isPin = 1'b0; it.exp = exp;
    sbq.push_back(it);
    apb(1'b0, a, 32'h0);
  endtask

  // expected pins packed as {irq, rst}
  task automatic pins(input logic [1:0] exp, input string tag);
    item_t it;
    it.tag = tag; it.isPin = 1'b1; it.exp = {30'h0, exp};
    sbq.push_back(it);
    pinReq = 1'b1;
    @(negedge clk); #1;
    pinReq = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tickEn = 1'b1;
    repeat (n) @(posedge clk);
    #1 tickEn = 1'b0;
  endtask

  task automatic doReset();
    @(posedge clk); #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    doReset();
    // R1 reset state
    rd(A_RELOAD, 32'hFFFFFFFF, "R1 reload");
    rd(A_COUNT, 32'hFFFFFFFF, "R1 count");
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_RAW, 32'h0, "R1 raw");
    rd(A_MSK, 32'h0, "R1 msk");
    rd(A_GUARD, 32'h0, "R1 guard");
    rd(A_TSTEN, 32'h0, "R1 tsten");
    pins(2'b00, "R1 pins");

    // R2 counting and reload
    wr(A_CTRL, 32'h3);
    wr(A_RELOAD, 32'd5);
    rd(A_COUNT, 32'd5, "R2 reload load");
    ticks(4);
    rd(A_COUNT, 32'd1, "R2 decrement");
    rd(A_RAW, 32'h0, "R3 no early expiry");
    // R3 first expiry
    ticks(1);
    rd(A_COUNT, 32'd0, "R3 reached zero");
    rd(A_RAW, 32'h1, "R3 raw set");
    rd(A_MSK, 32'h1, "R6 msk set");
    pins(2'b10, "R3 irq only");
    ticks(1);
    rd(A_COUNT, 32'd5, "R3 reload after expiry");
    // R4 second expiry
    ticks(5);
    pins(2'b11, "R4 reset raised");
    ticks(3);
    rd(A_COUNT, 32'd0, "R4 halted");
    // R6 masking
    wr(A_CTRL, 32'h0);
    pins(2'b00, "R6 masked pins");
    rd(A_MSK, 32'h0, "R6 msk masked");
    rd(A_RAW, 32'h1, "R6 raw kept");
    wr(A_CTRL, 32'hFFFFFFFF);
    rd(A_CTRL, 32'h3, "R6 ctrl upper bits zero");
    // R5 ack, halt persists
    wr(A_ACK, 32'h0);
    rd(A_RAW, 32'h0, "R5 raw cleared");
    rd(A_COUNT, 32'd5, "R5 ack reload");
    pins(2'b01, "R5 reset flag stays");
    ticks(2);
    rd(A_COUNT, 32'd5, "R4 halt after ack");
    wr(A_RELOAD, 32'd8);
    ticks(3);
    rd(A_COUNT, 32'd5, "R2 restart by reload");
    ticks(2);
    wr(A_ACK, 32'h1234);
    rd(A_COUNT, 32'd8, "R5 ack mid count");

    // R7 lock
    doReset();
    wr(A_CTRL, 32'h1);
    wr(A_GUARD, 32'h12345678);
    rd(A_GUARD, 32'h1, "R7 locked");
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, 32'h1, "R7 ctrl write ignored");
    wr(A_RELOAD, 32'd7);
    rd(A_RELOAD, 32'hFFFFFFFF, "R7 reload write ignored");
    wr(A_GUARD, KEY);
    rd(A_GUARD, 32'h0, "R7 unlocked");
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, 32'h2, "R7 ctrl after unlock");

    // R8 test mode
    wr(A_CTRL, 32'h0);
    wr(A_TSTDRV, 32'h2);
    wr(A_TSTEN, 32'h1);
    rd(A_TSTEN, 32'h1, "R8 tsten readback");
    pins(2'b10, "R8 drive irq");
    wr(A_TSTDRV, 32'h1);
    pins(2'b01, "R8 drive rst");
    wr(A_TSTEN, 32'h0);
    pins(2'b00, "R8 normal again");

    // R10 invalid and read-only offsets, ID words
    rd(12'h100, 32'h0, "R10 unmapped");
    rd(A_ACK, 32'h0, "R10 ack reads zero");
    rd(A_TSTDRV, 32'h0, "R10 tstdrv reads zero");
    rd(12'hFD0, 32'h11, "R10 id word 0");
    rd(12'hFFC, 32'h3C, "R10 id word 11");
    wr(A_COUNT, 32'h55);
    rd(A_COUNT, 32'hFFFFFFFF, "R10 count write ignored");
    wr(A_RAW, 32'h1);
    rd(A_RAW, 32'h0, "R10 raw write ignored");

    // R9 variant
    useAlt = 1'b1;
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, 32'h0, "R9 not frozen before bit0");
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, 32'h1, "R9 ctrl frozen");
    wr(A_TSTDRV, 32'h3);
    wr(A_TSTEN, 32'h1);
    rd(A_TSTEN, 32'h0, "R9 tsten absent");
    pins(2'b00, "R9 test drive absent");
    useAlt = 1'b0;

    repeat (2) @(posedge clk);
    if (sbq.size() != 0) compare("scoreboard leftover", sbq.size(), 0);
    summary();
  end
endmodule